// File: doc/BRIEF.md
# Instruction Dispatch Classifier

This block sits between register renaming and the issue and load/store queues of an out-of-order core. Each cycle it may receive a bundle of up to `SLOTS` renamed instructions, each carrying flags for squashed, load, store, non-speculative and no-op. It walks the bundle from slot 0 upward and decides the fate of each instruction. It can drop it, stop the bundle and request a stall, reserve a load/store queue entry and insert it into the issue queue, send it down the separate non-speculative insertion path, insert it as a plain instruction, or complete it on the spot as a no-op.

The issue queue's free-entry count is sampled with the bundle. It is decremented locally for every entry the bundle consumes, so a bundle that overruns the queue part-way stops at the exact slot where room runs out. All strobes, per-slot status bits, the stall request with the index of the first slot still to be replayed, and event counters are registered. They appear in the cycle after the bundle is sampled.

Top module: `dispatch_classifier`

## Requirements
- R1: While `rst_n` is low at a rising edge, every strobe, status bit, `stall_req`, `replay_idx` and every counter is cleared to zero.
- R2: All outputs are registered. A bundle sampled at one rising edge shows its results after that edge. When `bnd_valid` is low, the next cycle shows no strobe, no status bit and no stall, and no counter changes.
- R3: Only slots with index below `bnd_count` take part; higher slots produce nothing and are not counted.
- R4: A squashed slot is checked first. It is dropped even when the queue has no room, it adds one to `cnt_squashed`, and the walk continues with the next slot.
- R5: A non-squashed slot that finds zero free entries ends the walk. `stall_req` is then 1, `replay_idx` holds that slot's index, and `cnt_full` rises by one. That slot and every later slot produce nothing; this applies to a no-op too. Without a stall, `replay_idx` is 0.
- R6: Free room starts at `iq_free`. Each load, store, non-speculative or plain insertion uses one entry; a no-op uses none.
- R7: A load (priority over store, non-speculative and no-op flags) sets its bit in `lsq_load_rsv` and `iq_insert` and adds one to `cnt_load`.
- R8: A store that is not a load sets its bit in `lsq_store_rsv` and `iq_insert` and adds one to `cnt_store`.
- R9: A non-speculative instruction that is neither load nor store sets only its bit in `iq_nonspec_insert` and `st_can_commit`, and adds one to `cnt_nonspec`.
- R10: A no-op with no other flag set raises its bit in `nop_tail_adv`, `st_issued`, `st_executed` and `st_can_commit`, and adds one to `cnt_nop`.
- R11: An instruction with no flag set sets its bit in `iq_insert`. `cnt_dispatched` counts plain, load and store insertions.
- R12: Every counter is `CNT_W` bits wide and wraps to zero after its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_valid | input | 1 | Bundle present this cycle |
| bnd_count | input | $clog2(SLOTS+1) | Number of occupied slots, from slot 0 |
| slot_squashed | input | SLOTS | Per-slot squashed flag |
| slot_load | input | SLOTS | Per-slot load flag |
| slot_store | input | SLOTS | Per-slot store flag |
| slot_nonspec | input | SLOTS | Per-slot non-speculative flag |
| slot_nop | input | SLOTS | Per-slot no-op flag |
| iq_free | input | $clog2(IQ_DEPTH+1) | Free issue queue entries at bundle time |
| iq_insert | output | SLOTS | Normal issue queue insert strobe per slot |
| iq_nonspec_insert | output | SLOTS | Non-speculative insert strobe per slot |
| lsq_load_rsv | output | SLOTS | Load queue reservation strobe per slot |
| lsq_store_rsv | output | SLOTS | Store queue reservation strobe per slot |
| nop_tail_adv | output | SLOTS | Tail advance for an in-place no-op per slot |
| st_issued | output | SLOTS | Issued status per slot |
| st_executed | output | SLOTS | Executed status per slot |
| st_can_commit | output | SLOTS | Can-commit status per slot |
| stall_req | output | 1 | Stall request to the upstream stage |
| replay_idx | output | $clog2(SLOTS) | First undispatched slot when stalling |
| cnt_squashed | output | CNT_W | Squashed instructions dropped |
| cnt_full | output | CNT_W | Queue-full stall events |
| cnt_load | output | CNT_W | Loads dispatched |
| cnt_store | output | CNT_W | Stores dispatched |
| cnt_nonspec | output | CNT_W | Non-speculative instructions dispatched |
| cnt_nop | output | CNT_W | No-ops completed in place |
| cnt_dispatched | output | CNT_W | Plain, load and store insertions |

## Verification
Every result of a bundle, including the counter updates, is due one cycle after the rising edge that samples it. The bench drives a bundle on a falling edge and works out its expected outputs at once from the behavioural model. It compares them on the next falling edge, half a period after the design's registers have taken the new values. Directed bundles cover reset, idle cycles, short bundles, mixed flag priority, squashes into a full queue, no-ops ahead of a full queue and counter wrap. A long run of random bundles is checked the same way on every cycle.

// File: rtl/disp_pkg.sv
// Package: shared types for the dispatch classifier.
// Assumes: one action per slot, resolved before queue room is considered.
package disp_pkg;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,   // slot outside the bundle
        ACT_SKIP    = 3'd1,   // squashed, dropped
        ACT_LOAD    = 3'd2,
        ACT_STORE   = 3'd3,
        ACT_NONSPEC = 3'd4,
        ACT_NOP     = 3'd5,
        ACT_PLAIN   = 3'd6
    } slot_act_e;

endpackage

// File: rtl/disp_slot_decode.sv
// Module: per-slot flag priority decoder.
// Does: reduces the flags of one slot to a single action in fixed priority
// order (squashed, load, store, non-speculative, no-op, plain).
// Assumes: queue room is handled later by the scan, which checks it after
// squash and before every other action.
module disp_slot_decode
    import disp_pkg::*;
(
    input  logic      in_range,
    input  logic      f_squashed,
    input  logic      f_load,
    input  logic      f_store,
    input  logic      f_nonspec,
    input  logic      f_nop,
    output slot_act_e act
);

    // Purpose: pick the highest-priority action for this slot.
    always_comb begin
        if (!in_range)       act = ACT_NONE;
        else if (f_squashed) act = ACT_SKIP;
        else if (f_load)     act = ACT_LOAD;
        else if (f_store)    act = ACT_STORE;
        else if (f_nonspec)  act = ACT_NONSPEC;
        else if (f_nop)      act = ACT_NOP;
        else                 act = ACT_PLAIN;
    end

endmodule

// File: rtl/disp_scan.sv
// Module: in-order bundle walk against issue queue room.
// Does: walks the slots from 0 upward with a local free-entry count. It
// grants slots until one finds no room, then halts and reports that index.
// Assumes: skipped slots need no room; a no-op needs room to be checked
// but consumes none.
module disp_scan
    import disp_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int FREE_W = 6,
    parameter int IDX_W  = 2
) (
    input  slot_act_e          act [SLOTS],
    input  logic [FREE_W-1:0]  free_in,
    output logic [SLOTS-1:0]   take,
    output logic [SLOTS-1:0]   skip,
    output logic               stop,
    output logic [IDX_W-1:0]   stop_idx
);

    logic [FREE_W-1:0] room;

    // Purpose: ordered walk with early termination on an exhausted queue.
    always_comb begin
        room     = free_in;
        take     = '0;
        skip     = '0;
        stop     = 1'b0;
        stop_idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!stop) begin
                if (act[i] == ACT_SKIP) begin
                    skip[i] = 1'b1;
                end else if (act[i] != ACT_NONE) begin
                    if (room == '0) begin
                        stop     = 1'b1;
                        stop_idx = IDX_W'(i);
                    end else begin
                        take[i] = 1'b1;
                        if (act[i] != ACT_NOP) room = room - 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/disp_counter.sv
// Module: wrapping event counter.
// Does: adds a per-cycle increment, wrapping at its width.
// Assumes: synchronous active-low reset.
module disp_counter #(
    parameter int W     = 16,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     count
);

    // Purpose: accumulate the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + W'(inc);
    end

endmodule

// File: rtl/dispatch_classifier.sv
// Module: instruction dispatch classifier (top).
// Does: decodes each slot of a renamed bundle and walks it in order against
// issue queue room. It registers insert strobes, status bits, the stall
// request with its replay index, and event counters.
// Assumes: iq_free is never above IQ_DEPTH; results appear one cycle after
// the bundle is sampled.
module dispatch_classifier
    import disp_pkg::*;
#(
    parameter int SLOTS    = 4,
    parameter int IQ_DEPTH = 32,
    parameter int CNT_W    = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bnd_valid,
    input  logic [$clog2(SLOTS+1)-1:0]         bnd_count,
    input  logic [SLOTS-1:0]                   slot_squashed,
    input  logic [SLOTS-1:0]                   slot_load,
    input  logic [SLOTS-1:0]                   slot_store,
    input  logic [SLOTS-1:0]                   slot_nonspec,
    input  logic [SLOTS-1:0]                   slot_nop,
    input  logic [$clog2(IQ_DEPTH+1)-1:0]      iq_free,
    output logic [SLOTS-1:0]                   iq_insert,
    output logic [SLOTS-1:0]                   iq_nonspec_insert,
    output logic [SLOTS-1:0]                   lsq_load_rsv,
    output logic [SLOTS-1:0]                   lsq_store_rsv,
    output logic [SLOTS-1:0]                   nop_tail_adv,
    output logic [SLOTS-1:0]                   st_issued,
    output logic [SLOTS-1:0]                   st_executed,
    output logic [SLOTS-1:0]                   st_can_commit,
    output logic                               stall_req,
    output logic [$clog2(SLOTS)-1:0]           replay_idx,
    output logic [CNT_W-1:0]                   cnt_squashed,
    output logic [CNT_W-1:0]                   cnt_full,
    output logic [CNT_W-1:0]                   cnt_load,
    output logic [CNT_W-1:0]                   cnt_store,
    output logic [CNT_W-1:0]                   cnt_nonspec,
    output logic [CNT_W-1:0]                   cnt_nop,
    output logic [CNT_W-1:0]                   cnt_dispatched
);

    localparam int CW     = $clog2(SLOTS+1);
    localparam int FREE_W = $clog2(IQ_DEPTH+1);
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int NCNT   = 7;

    slot_act_e          act [SLOTS];
    logic [SLOTS-1:0]   take, skip;
    logic               stop;
    logic [IDX_W-1:0]   stop_idx;

    // Per-slot priority decode.
    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
        disp_slot_decode u_dec (
            .in_range   (bnd_valid && (bnd_count > CW'(g))),
            .f_squashed (slot_squashed[g]),
            .f_load     (slot_load[g]),
            .f_store    (slot_store[g]),
            .f_nonspec  (slot_nonspec[g]),
            .f_nop      (slot_nop[g]),
            .act        (act[g])
        );
    end

    disp_scan #(.SLOTS(SLOTS), .FREE_W(FREE_W), .IDX_W(IDX_W)) u_scan (
        .act      (act),
        .free_in  (iq_free),
        .take     (take),
        .skip     (skip),
        .stop     (stop),
        .stop_idx (stop_idx)
    );

    logic [SLOTS-1:0] ld_n, st_n, ns_n, nop_n, plain_n;

    // Purpose: split granted slots into per-path strobes.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            ld_n[i]    = take[i] && (act[i] == ACT_LOAD);
            st_n[i]    = take[i] && (act[i] == ACT_STORE);
            ns_n[i]    = take[i] && (act[i] == ACT_NONSPEC);
            nop_n[i]   = take[i] && (act[i] == ACT_NOP);
            plain_n[i] = take[i] && (act[i] == ACT_PLAIN);
        end
    end

    // Purpose: register strobes, status bits and the stall report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iq_insert         <= '0;
            iq_nonspec_insert <= '0;
            lsq_load_rsv      <= '0;
            lsq_store_rsv     <= '0;
            nop_tail_adv      <= '0;
            st_issued         <= '0;
            st_executed       <= '0;
            st_can_commit     <= '0;
            stall_req         <= 1'b0;
            replay_idx        <= '0;
        end else begin
            iq_insert         <= plain_n | ld_n | st_n;
            iq_nonspec_insert <= ns_n;
            lsq_load_rsv      <= ld_n;
            lsq_store_rsv     <= st_n;
            nop_tail_adv      <= nop_n;
            st_issued         <= nop_n;
            st_executed       <= nop_n;
            st_can_commit     <= nop_n | ns_n;
            stall_req         <= stop;
            replay_idx        <= stop ? stop_idx : '0;
        end
    end

    // Event counters, one instance per event kind.
    logic [CW-1:0]    inc_v [NCNT];
    logic [CNT_W-1:0] cnt_v [NCNT];

    assign inc_v[0] = CW'($countones(skip));
    assign inc_v[1] = CW'(stop);
    assign inc_v[2] = CW'($countones(ld_n));
    assign inc_v[3] = CW'($countones(st_n));
    assign inc_v[4] = CW'($countones(ns_n));
    assign inc_v[5] = CW'($countones(nop_n));
    assign inc_v[6] = CW'($countones(plain_n | ld_n | st_n));

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        disp_counter #(.W(CNT_W), .INC_W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_v[c]),
            .count (cnt_v[c])
        );
    end

    assign cnt_squashed   = cnt_v[0];
    assign cnt_full       = cnt_v[1];
    assign cnt_load       = cnt_v[2];
    assign cnt_store      = cnt_v[3];
    assign cnt_nonspec    = cnt_v[4];
    assign cnt_nop        = cnt_v[5];
    assign cnt_dispatched = cnt_v[6];

    // A completed no-op never occupies an issue entry.
    assert_nop_no_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (nop_tail_adv & (iq_insert | iq_nonspec_insert)) == '0);

    // The non-speculative path is exclusive of every other insertion.
    assert_nonspec_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iq_nonspec_insert & (iq_insert | lsq_load_rsv | lsq_store_rsv)) == '0);

    // A load/store reservation always pairs with an issue queue insert.
    assert_lsq_with_iq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((lsq_load_rsv | lsq_store_rsv) & ~iq_insert) == '0);

    // One slot never reserves both a load and a store entry.
    assert_ld_st_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsq_load_rsv & lsq_store_rsv) == '0);

    // Nothing at or after the replay index is acted on during a stall.
    assert_stop_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> ((iq_insert | iq_nonspec_insert | nop_tail_adv) >> replay_idx) == '0);

    // Every stall is counted exactly once.
    assert_full_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> cnt_full == CNT_W'($past(cnt_full) + 1'b1));

endmodule

// File: tb/dispatch_classifier_tb.sv
// Bench: behavioural model of the dispatch walk, compared every cycle.
module dispatch_classifier_tb;

    localparam int SLOTS    = 4;
    localparam int IQ_DEPTH = 32;
    localparam int CNT_W    = 8;
    localparam int CMASK    = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bnd_valid = 1'b0;
    logic [2:0] bnd_count = '0;
    logic [SLOTS-1:0] f_sq = '0, f_ld = '0, f_st = '0, f_ns = '0, f_nop = '0;
    logic [5:0] iq_free = '0;

    logic [SLOTS-1:0] iq_insert, iq_nonspec_insert, lsq_load_rsv, lsq_store_rsv;
    logic [SLOTS-1:0] nop_tail_adv, st_issued, st_executed, st_can_commit;
    logic stall_req;
    logic [1:0] replay_idx;
    logic [CNT_W-1:0] cnt_squashed, cnt_full, cnt_load, cnt_store;
    logic [CNT_W-1:0] cnt_nonspec, cnt_nop, cnt_dispatched;

    always #4 clk = ~clk;

    dispatch_classifier #(.SLOTS(SLOTS), .IQ_DEPTH(IQ_DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_count(bnd_count),
        .slot_squashed(f_sq), .slot_load(f_ld), .slot_store(f_st),
        .slot_nonspec(f_ns), .slot_nop(f_nop), .iq_free(iq_free),
        .iq_insert(iq_insert), .iq_nonspec_insert(iq_nonspec_insert),
        .lsq_load_rsv(lsq_load_rsv), .lsq_store_rsv(lsq_store_rsv),
        .nop_tail_adv(nop_tail_adv), .st_issued(st_issued), .st_executed(st_executed),
        .st_can_commit(st_can_commit), .stall_req(stall_req), .replay_idx(replay_idx),
        .cnt_squashed(cnt_squashed), .cnt_full(cnt_full), .cnt_load(cnt_load),
        .cnt_store(cnt_store), .cnt_nonspec(cnt_nonspec), .cnt_nop(cnt_nop),
        .cnt_dispatched(cnt_dispatched)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // model expectations
    logic [SLOTS-1:0] e_ins, e_ns, e_ld, e_st, e_nop;
    logic e_stall;
    int e_idx;
    int c_sq, c_full, c_ld, c_st, c_ns, c_nop, c_disp;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural model of one sampled bundle.
    task automatic model();
        int room;
        bit halt;
        e_ins = '0; e_ns = '0; e_ld = '0; e_st = '0; e_nop = '0;
        e_stall = 0; e_idx = 0;
        if (!rst_n) begin
            c_sq = 0; c_full = 0; c_ld = 0; c_st = 0; c_ns = 0; c_nop = 0; c_disp = 0;
            return;
        end
        if (!bnd_valid) return;
        room = int'(iq_free);
        halt = 0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!halt && i < int'(bnd_count)) begin
                if (f_sq[i]) c_sq++;
                else if (room == 0) begin
                    halt = 1; e_stall = 1; e_idx = i; c_full++;
                end else if (f_ld[i]) begin
                    e_ld[i] = 1; e_ins[i] = 1; room--; c_ld++; c_disp++;
                end else if (f_st[i]) begin
                    e_st[i] = 1; e_ins[i] = 1; room--; c_st++; c_disp++;
                end else if (f_ns[i]) begin
                    e_ns[i] = 1; room--; c_ns++;
                end else if (f_nop[i]) begin
                    e_nop[i] = 1; c_nop++;
                end else begin
                    e_ins[i] = 1; room--; c_disp++;
                end
            end
        end
    endtask

    task automatic compare_all();
        chk("R11", "iq_insert", 32'(iq_insert), 32'(e_ins));
        chk("R9", "iq_nonspec_insert", 32'(iq_nonspec_insert), 32'(e_ns));
        chk("R7", "lsq_load_rsv", 32'(lsq_load_rsv), 32'(e_ld));
        chk("R8", "lsq_store_rsv", 32'(lsq_store_rsv), 32'(e_st));
        chk("R10", "nop_tail_adv", 32'(nop_tail_adv), 32'(e_nop));
        chk("R10", "st_issued", 32'(st_issued), 32'(e_nop));
        chk("R10", "st_executed", 32'(st_executed), 32'(e_nop));
        chk("R9", "st_can_commit", 32'(st_can_commit), 32'(e_nop | e_ns));
        chk("R5", "stall_req", 32'(stall_req), 32'(e_stall));
        chk("R5", "replay_idx", 32'(replay_idx), 32'(e_idx));
        chk("R4", "cnt_squashed", 32'(cnt_squashed), 32'(c_sq & CMASK));
        chk("R5", "cnt_full", 32'(cnt_full), 32'(c_full & CMASK));
        chk("R7", "cnt_load", 32'(cnt_load), 32'(c_ld & CMASK));
        chk("R8", "cnt_store", 32'(cnt_store), 32'(c_st & CMASK));
        chk("R9", "cnt_nonspec", 32'(cnt_nonspec), 32'(c_ns & CMASK));
        chk("R10", "cnt_nop", 32'(cnt_nop), 32'(c_nop & CMASK));
        chk("R11", "cnt_dispatched", 32'(cnt_dispatched), 32'(c_disp & CMASK));
    endtask

    // Drive one bundle on a falling edge; check the results one cycle later.
    task automatic cyc(input bit v, input int cnt, input logic [SLOTS-1:0] sq,
                       input logic [SLOTS-1:0] ld, input logic [SLOTS-1:0] st,
                       input logic [SLOTS-1:0] ns, input logic [SLOTS-1:0] nop,
                       input int fr);
        bnd_valid = v; bnd_count = 3'(cnt);
        f_sq = sq; f_ld = ld; f_st = st; f_ns = ns; f_nop = nop;
        iq_free = 6'(fr);
        model();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 0;
        cyc(1, 4, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 5);
        cyc(1, 4, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 5);
        // R1: reset state
        chk("R1", "strobes", 32'(iq_insert | nop_tail_adv | st_can_commit), 0);
        chk("R1", "counters", 32'(cnt_squashed | cnt_nop | cnt_dispatched), 0);
        rst_n = 1;

        // R2: idle cycle leaves nothing
        cyc(0, 4, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 8);
        chk("R2", "idle iq_insert", 32'(iq_insert), 0);
        chk("R2", "idle cnt_load", 32'(cnt_load), 0);

        // R3: short bundle of two plain slots
        cyc(1, 2, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 8);
        chk("R3", "iq_insert", 32'(iq_insert), 32'h3);

        // R6: two free, four plain -> stop at slot 2
        cyc(1, 4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 2);
        chk("R6", "iq_insert", 32'(iq_insert), 32'h3);
        chk("R5", "replay_idx", 32'(replay_idx), 2);

        // R4: squashed slot dropped with no room, next slot stalls
        cyc(1, 4, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 0);
        chk("R4", "stall idx", 32'(replay_idx), 1);
        chk("R4", "cnt_squashed", 32'(cnt_squashed), 1);

        // R10 / R6: no-ops use no entry; one free entry, stop at slot 3
        cyc(1, 4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h3, 1);
        chk("R10", "nop_tail_adv", 32'(nop_tail_adv), 32'h3);
        chk("R6", "iq_insert", 32'(iq_insert), 32'h4);
        chk("R5", "replay_idx", 32'(replay_idx), 3);

        // R7/R8/R9: priority among flags
        cyc(1, 4, 4'h0, 4'h1, 4'h3, 4'h7, 4'hF, 8);
        chk("R7", "lsq_load_rsv", 32'(lsq_load_rsv), 32'h1);
        chk("R8", "lsq_store_rsv", 32'(lsq_store_rsv), 32'h2);
        chk("R9", "iq_nonspec_insert", 32'(iq_nonspec_insert), 32'h4);
        chk("R9", "st_can_commit", 32'(st_can_commit), 32'hC);

        // R5: full queue stops even a no-op
        cyc(1, 1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 0);
        chk("R5", "stall_req", 32'(stall_req), 1);
        chk("R5", "nop_tail_adv", 32'(nop_tail_adv), 0);

        // Random bundles with an occasional reset
        for (int n = 0; n < 3000; n++) begin
            rst_n = ($urandom_range(0, 199) != 0);
            cyc(($urandom_range(0, 7) != 0), $urandom_range(0, SLOTS),
                4'($urandom), 4'($urandom & $urandom), 4'($urandom & $urandom),
                4'($urandom & $urandom), 4'($urandom), $urandom_range(0, 5));
        end
        rst_n = 1;

        // R12: counter wrap, 70 bundles of four no-ops = 280 -> 24
        rst_n = 0;
        cyc(0, 0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 0);
        rst_n = 1;
        for (int n = 0; n < 70; n++)
            cyc(1, 4, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 3);
        chk("R12", "cnt_nop wrap", 32'(cnt_nop), 32'd24);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule